// File: doc/BRIEF.md
# Programmable Vectored Interrupt Controller

This block is a memory-mapped interrupt controller serving one processor. A handful of external request lines enter it. Each line has a configuration word holding its vector, a 4-bit priority, a mask, its detection mode (edge or level), its active polarity and a read-only activity flag, along with a destination word whose bit 0 routes the line to this processor. The controller latches requests, chooses the best unmasked one whose priority beats the processor's task-priority threshold, and raises `irq_out`.

Software reads the acknowledge register to get the vector of the chosen source. That read moves the source into service and drops `irq_out`. A later write to the end-of-interrupt register retires it. When nothing qualifies, the acknowledge read returns a programmable spurious vector. A global configuration bit restarts the controller. It reads back as 1 while the restart runs and clears itself afterwards.

The controller runs a three-state machine:
- `S_INIT` reinitialises all registers for `RST_CYCLES` cycles. It is entered on the reset pin and on a write of the restart bit.
- `S_INIT` moves to `S_IDLE` when its counter runs out.
- `S_IDLE` delivers requests. It moves to `S_SERVICE` on an acknowledge read that finds a winner.
- `S_SERVICE` holds one source in service. It returns to `S_IDLE` on an end-of-interrupt write.
- A restart write sends `S_IDLE` or `S_SERVICE` back to `S_INIT`.

Top module: `vec_intc`

## Requirements
- R1: After reset the controller behaves as follows. Every source configuration word reads 0x8000_0000 (masked, all other fields 0). Every destination reads 0. Task priority reads 15, the spurious vector reads 0xFF, the configuration word reads 0 and `irq_out` is low.
- R2: The feature word at 0x04 reads version in [7:0] (parameter VERSION), last processor index 0 in [12:8] and last source index NUM_SRC-1 in [23:16].
- R3: A source configuration word (0x20+8*n) holds vector [7:0], priority [19:16], polarity bit 22 (1 = active high or rising), sense bit 23 (1 = level, 0 = edge), activity bit 30 (read-only) and mask bit 31. The mask bit is always writable. The other fields take a write only if the stored mask is 1 and activity is 0; otherwise they keep their value.
- R4: In edge mode, the selected edge of the input latches a request. The request stays pending after the input returns inactive, until it is acknowledged.
- R5: In level mode, the request follows the live input. After end-of-interrupt, an input that is still active raises the request again.
- R6: A source is delivered only when it is unmasked, its destination bit 0 (at 0x24+8*n) is set, its priority is nonzero and its priority is strictly greater than the task priority (0x0C, [3:0]). A task priority of 15 blocks everything.
- R7: Among qualifying sources, the highest priority wins. Ties go to the lowest-numbered source.
- R8: A read of 0x10 in `S_IDLE` with a winner returns the winner's vector, puts the winner in service and drops `irq_out` for the next cycle. Any other acknowledge read returns the spurious vector (0x08, [7:0]). While a source is in service, nothing is delivered.
- R9: Any write to 0x14 in `S_SERVICE` retires the in-service source and returns to `S_IDLE`, where remaining requests are delivered again.
- R10: Writing 1 to bit 0 of 0x00 enters `S_INIT`. Bit 0 reads 1 for `RST_CYCLES` cycles and then 0. All registers return to their R1 values, and writes during `S_INIT` are ignored.
- R11: A source's activity bit is 1 from the cycle its request is latched until its end-of-interrupt, and reads 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after the read |
| irq_src | input | NUM_SRC | External request lines |
| irq_out | output | 1 | Interrupt to the processor |

## Verification
The hardest situation to reach is a set of edge requests pending together, so that the order in which acknowledges hand them out exposes the priority and tie-break rule. The bench pulses every non-empty subset of four sources in the same cycle, with two sources sharing a priority. It then drains each subset through acknowledge and end-of-interrupt pairs, checking every vector against a winner computed in the bench, and ends each drain with a spurious read. The edit lock is reached by latching an edge on a masked source, so that activity is set while the mask is still on.

// File: rtl/vic_pkg.sv
package vic_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int VEC_W  = 8;
    localparam int PRI_W  = 4;

    localparam logic [ADDR_W-1:0] A_CFG      = 8'h00;
    localparam logic [ADDR_W-1:0] A_FEAT     = 8'h04;
    localparam logic [ADDR_W-1:0] A_SPUR     = 8'h08;
    localparam logic [ADDR_W-1:0] A_TPRI     = 8'h0C;
    localparam logic [ADDR_W-1:0] A_ACK      = 8'h10;
    localparam logic [ADDR_W-1:0] A_EOI      = 8'h14;
    localparam logic [ADDR_W-1:0] A_SRC_BASE = 8'h20;
    localparam int                SRC_STRIDE = 8;

    localparam int CFG_RST_B  = 0;
    localparam int VP_MASK_B  = 31;
    localparam int VP_ACT_B   = 30;
    localparam int VP_SENSE_B = 23;
    localparam int VP_POL_B   = 22;
    localparam int VP_PRI_LSB = 16;
    localparam int VP_VEC_LSB = 0;

    typedef enum logic [1:0] {
        S_INIT,
        S_IDLE,
        S_SERVICE
    } ctl_state_t;

    typedef struct packed {
        logic             mask;
        logic             sense;
        logic             pol;
        logic [PRI_W-1:0] pri;
        logic [VEC_W-1:0] vec;
    } src_cfg_t;

    localparam src_cfg_t CFG_RESET = '{mask: 1'b1, sense: 1'b0, pol: 1'b0,
                                       pri: '0, vec: '0};

endpackage

// File: rtl/vic_source.sv
module vic_source
    import vic_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clear,
    input  logic     wr_cfg,
    input  src_cfg_t wr_val,
    input  logic     wr_dest,
    input  logic     dest_val,
    input  logic     req_in,
    input  logic     take,
    input  logic     retire,
    output src_cfg_t cfg,
    output logic     dest,
    output logic     active,
    output logic     in_svc,
    output logic     eligible
);

    logic prev_q;
    logic edge_pend_q;
    logic lvl_on;
    logic edge_hit;
    logic pending;

    always_comb begin
        lvl_on   = cfg.pol ? req_in : ~req_in;
        edge_hit = cfg.pol ? (req_in & ~prev_q) : (~req_in & prev_q);
        pending  = cfg.sense ? (lvl_on & ~in_svc) : edge_pend_q;
        active   = pending | in_svc;
        eligible = pending & ~cfg.mask & dest & (cfg.pri != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg         <= CFG_RESET;
            dest        <= 1'b0;
            prev_q      <= 1'b0;
            edge_pend_q <= 1'b0;
            in_svc      <= 1'b0;
        end else if (clear) begin
            cfg         <= CFG_RESET;
            dest        <= 1'b0;
            prev_q      <= req_in;
            edge_pend_q <= 1'b0;
            in_svc      <= 1'b0;
        end else begin
            prev_q <= req_in;
            if (wr_cfg) begin
                cfg.mask <= wr_val.mask;
                if (cfg.mask && !active) begin
                    cfg.sense <= wr_val.sense;
                    cfg.pol   <= wr_val.pol;
                    cfg.pri   <= wr_val.pri;
                    cfg.vec   <= wr_val.vec;
                end
            end
            if (wr_dest) begin
                dest <= dest_val;
            end
            if (take) begin
                edge_pend_q <= 1'b0;
            end else if (edge_hit && !cfg.sense) begin
                edge_pend_q <= 1'b1;
            end
            if (take) begin
                in_svc <= 1'b1;
            end else if (retire) begin
                in_svc <= 1'b0;
            end
        end
    end

    // R3: fields other than mask are locked while unmasked or active
    a_r3_edit_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cfg && !clear && (!cfg.mask || active)) |=>
            ($stable(cfg.vec) && $stable(cfg.pri) && $stable(cfg.sense) && $stable(cfg.pol)))
        else $error("edit lock violated");

    // R4: a latched edge request survives until it is taken
    a_r4_edge_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_pend_q && !take && !clear) |=> edge_pend_q)
        else $error("edge request lost");

endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
    import vic_pkg::*;
#(
    parameter int N     = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
)(
    input  logic [N-1:0]            elig,
    input  logic [N-1:0][PRI_W-1:0] pri,
    input  logic [PRI_W-1:0]        thresh,
    output logic                    found,
    output logic [IDX_W-1:0]        win
);

    logic [PRI_W-1:0] best;

    always_comb begin
        found = 1'b0;
        best  = '0;
        win   = '0;
        for (int i = 0; i < N; i++) begin
            if (elig[i] && (pri[i] > thresh) && (!found || (pri[i] > best))) begin
                found = 1'b1;
                best  = pri[i];
                win   = IDX_W'(i);
            end
        end
    end

    // R6 / R7: winner beats the threshold, no lower index ties or beats it,
    // no higher index beats it
    always_comb begin
        if (found) begin
            a_r6_above_thresh: assert (elig[win] && (pri[win] > thresh))
                else $error("winner does not qualify");
            for (int j = 0; j < N; j++) begin
                if (elig[j] && (j < int'(win))) begin
                    a_r7_low_index: assert (pri[j] < pri[win])
                        else $error("lower index should have won");
                end
                if (elig[j] && (j > int'(win))) begin
                    a_r7_high_index: assert (pri[j] <= pri[win])
                        else $error("higher priority skipped");
                end
            end
        end
    end

endmodule

// File: rtl/vec_intc.sv
module vec_intc
    import vic_pkg::*;
#(
    parameter int NUM_SRC    = 4,
    parameter int RST_CYCLES = 4,
    parameter int VERSION    = 2,
    localparam int IDX_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int CNT_W     = $clog2(RST_CYCLES + 1)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_SRC-1:0] irq_src,
    output logic              irq_out
);

    ctl_state_t state, state_nx;
    logic [CNT_W-1:0] rst_cnt;
    logic [IDX_W-1:0] svc_idx;
    logic [PRI_W-1:0] task_pri;
    logic [VEC_W-1:0] spur_vec;

    logic wr_op, rd_op, in_init;
    logic reset_go, ack_go, eoi_go;
    logic found;
    logic [IDX_W-1:0] win;
    src_cfg_t wr_val;
    logic unused_bits;

    src_cfg_t                    cfg     [NUM_SRC];
    logic [NUM_SRC-1:0]          dest, active, in_svc, elig;
    logic [NUM_SRC-1:0][PRI_W-1:0] pri_vec;
    logic [NUM_SRC-1:0]          hit_vp, hit_dest;
    logic [DATA_W-1:0]           rd_mux;

    always_comb begin
        wr_op    = bus_en & bus_wr;
        rd_op    = bus_en & ~bus_wr;
        in_init  = (state == S_INIT);
        reset_go = wr_op & !in_init & (bus_addr == A_CFG) & bus_wdata[CFG_RST_B];
        ack_go   = rd_op & (bus_addr == A_ACK) & (state == S_IDLE) & found;
        eoi_go   = wr_op & (bus_addr == A_EOI) & (state == S_SERVICE);
        wr_val   = '{mask:  bus_wdata[VP_MASK_B],
                     sense: bus_wdata[VP_SENSE_B],
                     pol:   bus_wdata[VP_POL_B],
                     pri:   bus_wdata[VP_PRI_LSB +: PRI_W],
                     vec:   bus_wdata[VP_VEC_LSB +: VEC_W]};
        unused_bits = ^{bus_wdata[30:24], bus_wdata[21:20], bus_wdata[15:8]};
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        localparam logic [ADDR_W-1:0] VP_A = A_SRC_BASE + ADDR_W'(SRC_STRIDE * g);
        localparam logic [ADDR_W-1:0] DS_A = VP_A + ADDR_W'(4);

        assign hit_vp[g]   = (bus_addr == VP_A);
        assign hit_dest[g] = (bus_addr == DS_A);
        assign pri_vec[g]  = cfg[g].pri;

        vic_source u_src (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear    (in_init),
            .wr_cfg   (wr_op & !in_init & hit_vp[g]),
            .wr_val   (wr_val),
            .wr_dest  (wr_op & !in_init & hit_dest[g]),
            .dest_val (bus_wdata[0]),
            .req_in   (irq_src[g]),
            .take     (ack_go && (win == IDX_W'(g))),
            .retire   (eoi_go && (svc_idx == IDX_W'(g))),
            .cfg      (cfg[g]),
            .dest     (dest[g]),
            .active   (active[g]),
            .in_svc   (in_svc[g]),
            .eligible (elig[g])
        );
    end

    vic_arbiter #(.N(NUM_SRC)) u_arb (
        .elig   (elig),
        .pri    (pri_vec),
        .thresh (task_pri),
        .found  (found),
        .win    (win)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_INIT:    if (rst_cnt == '0) state_nx = S_IDLE;
            S_IDLE:    if (reset_go)      state_nx = S_INIT;
                       else if (ack_go)   state_nx = S_SERVICE;
            S_SERVICE: if (reset_go)      state_nx = S_INIT;
                       else if (eoi_go)   state_nx = S_IDLE;
            default:   state_nx = S_INIT;
        endcase
    end

    // state register and controller-owned registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_INIT;
            rst_cnt  <= CNT_W'(RST_CYCLES - 1);
            svc_idx  <= '0;
            task_pri <= '1;
            spur_vec <= '1;
        end else begin
            state <= state_nx;
            if (reset_go) begin
                rst_cnt <= CNT_W'(RST_CYCLES - 1);
            end else if (in_init && rst_cnt != '0) begin
                rst_cnt <= rst_cnt - 1'b1;
            end
            if (ack_go) begin
                svc_idx <= win;
            end
            if (in_init) begin
                task_pri <= '1;
                spur_vec <= '1;
            end else if (wr_op && bus_addr == A_TPRI) begin
                task_pri <= bus_wdata[PRI_W-1:0];
            end else if (wr_op && bus_addr == A_SPUR) begin
                spur_vec <= bus_wdata[VEC_W-1:0];
            end
        end
    end

    // outputs
    always_comb begin
        irq_out = (state == S_IDLE) && found;
        rd_mux  = '0;
        if (bus_addr == A_CFG) begin
            rd_mux[CFG_RST_B] = in_init;
        end else if (bus_addr == A_FEAT) begin
            rd_mux[7:0]   = 8'(VERSION);
            rd_mux[12:8]  = 5'd0;
            rd_mux[23:16] = 8'(NUM_SRC - 1);
        end else if (bus_addr == A_SPUR) begin
            rd_mux[VEC_W-1:0] = spur_vec;
        end else if (bus_addr == A_TPRI) begin
            rd_mux[PRI_W-1:0] = task_pri;
        end else if (bus_addr == A_ACK) begin
            rd_mux[VEC_W-1:0] = ack_go ? cfg[win].vec : spur_vec;
        end
        for (int i = 0; i < NUM_SRC; i++) begin
            if (hit_vp[i]) begin
                rd_mux[VP_MASK_B]               = cfg[i].mask;
                rd_mux[VP_ACT_B]                = active[i];
                rd_mux[VP_SENSE_B]              = cfg[i].sense;
                rd_mux[VP_POL_B]                = cfg[i].pol;
                rd_mux[VP_PRI_LSB +: PRI_W]     = cfg[i].pri;
                rd_mux[VP_VEC_LSB +: VEC_W]     = cfg[i].vec;
            end
            if (hit_dest[i]) begin
                rd_mux[0] = dest[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (rd_op) begin
            bus_rdata <= rd_mux;
        end
    end

    // R8: a successful acknowledge drops the interrupt for the next cycle
    a_r8_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_op && bus_addr == A_ACK && irq_out) |=> !irq_out)
        else $error("irq_out stayed high after acknowledge");

    // R8: at most one source in service
    a_r8_single_svc: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(in_svc))
        else $error("more than one source in service");

    // R6: top task priority blocks delivery
    a_r6_tpri_block: assert property (@(posedge clk) disable iff (!rst_n)
        (task_pri == '1) |-> !irq_out)
        else $error("delivery above task priority 15");

    // R9: end-of-interrupt returns to idle
    a_r9_eoi_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_go && !reset_go) |=> (state == S_IDLE))
        else $error("EOI did not return to idle");

    // R10: restart write enters initialisation
    a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
        reset_go |=> (state == S_INIT))
        else $error("restart bit ignored");

endmodule

// File: tb/vec_intc_test.sv
module vec_intc_test;

    localparam int NSRC = 4;
    localparam int RSTC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NSRC-1:0] irq_src = '0;
    logic        irq_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    vec_intc #(.NUM_SRC(NSRC), .RST_CYCLES(RSTC), .VERSION(2)) uut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_src(irq_src), .irq_out(irq_out)
    );

    function automatic logic [31:0] vp(bit m, bit s, bit p, int pri, int vec);
        return {m, 1'b0, 6'd0, s, p, 2'd0, 4'(pri), 8'd0, 8'(vec)};
    endfunction

    function automatic logic [7:0] vpa(int i);
        return 8'(8'h20 + 8 * i);
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] d;
        int pri_a [NSRC];
        pri_a = '{3, 5, 5, 2};

        idle(3);
        rst_n = 1'b1;
        idle(RSTC + 2);

        // R1 reset state
        check("R1 irq_out", 32'(irq_out), 0);
        for (int i = 0; i < NSRC; i++) begin
            rd(vpa(i), d);     check("R1 vp", d, 32'h8000_0000);
            rd(vpa(i) + 4, d); check("R1 dest", d, 0);
        end
        rd(8'h0C, d); check("R1 tpri", d, 15);
        rd(8'h08, d); check("R1 spur", d, 32'hFF);
        rd(8'h00, d); check("R1 cfg", d, 0);
        rd(8'h10, d); check("R8 spurious after reset", d, 32'hFF);

        // R2 feature word
        rd(8'h04, d); check("R2 feature", d, (32'(NSRC - 1) << 16) | 32'd2);

        // R6 threshold sweep on level source 0
        wr(vpa(0) + 4, 1);
        for (int p = 0; p < 16; p++) begin
            wr(vpa(0), vp(1, 1, 1, p, 8'h40 + p));
            wr(vpa(0), vp(0, 1, 1, p, 8'h40 + p));
            irq_src[0] = 1'b1;
            for (int t = 0; t < 16; t++) begin
                wr(8'h0C, t);
                check($sformatf("R6 p=%0d t=%0d", p, t), 32'(irq_out), 32'(p > t));
            end
            irq_src[0] = 1'b0;
            wr(vpa(0), vp(1, 1, 1, p, 8'h40 + p));
        end

        // R6 destination bit 0 gates delivery
        wr(8'h0C, 0);
        wr(8'h08, 8'hA5);
        wr(vpa(0) + 4, 0);
        wr(vpa(0), vp(1, 1, 1, 5, 8'h45));
        wr(vpa(0), vp(0, 1, 1, 5, 8'h45));
        irq_src[0] = 1'b1;
        idle(1);
        check("R6 dest clear blocks", 32'(irq_out), 0);
        wr(vpa(0) + 4, 1);
        check("R6 dest set delivers", 32'(irq_out), 1);

        // R8 / R5 level acknowledge and re-raise
        rd(8'h10, d); check("R8 ack vector", d, 8'h45);
        check("R8 irq drops", 32'(irq_out), 0);
        rd(8'h10, d); check("R8 spurious in service", d, 8'hA5);
        wr(8'h14, 0);
        check("R5 level re-raises after EOI", 32'(irq_out), 1);
        rd(8'h10, d); check("R8 ack vector again", d, 8'h45);
        irq_src[0] = 1'b0;
        wr(8'h14, 0);
        check("R5 level gone", 32'(irq_out), 0);
        rd(vpa(0), d); check("R11 activity clear", d[30], 0);
        wr(vpa(0), vp(1, 1, 1, 5, 8'h45));

        // R4 / R3 / R11 edge on masked source 1
        wr(vpa(1) + 4, 1);
        wr(vpa(1), vp(1, 0, 1, 7, 8'h51));
        irq_src[1] = 1'b1; idle(1); irq_src[1] = 1'b0; idle(1);
        check("R6 masked not delivered", 32'(irq_out), 0);
        rd(vpa(1), d); check("R11 activity on latch", d, vp(1, 0, 1, 7, 8'h51) | 32'h4000_0000);
        wr(vpa(1), vp(1, 0, 1, 7, 8'h99));
        rd(vpa(1), d); check("R3 locked while active", d[7:0], 8'h51);
        wr(vpa(1), vp(0, 0, 1, 7, 8'h51));
        check("R4 edge persists", 32'(irq_out), 1);
        rd(8'h10, d); check("R8 edge ack", d, 8'h51);
        rd(vpa(1), d); check("R11 active in service", d[30], 1);
        wr(8'h14, 0);
        check("R9 edge retired", 32'(irq_out), 0);
        rd(vpa(1), d); check("R11 cleared by EOI", d[30], 0);
        wr(vpa(1), vp(0, 0, 1, 7, 8'h77));
        rd(vpa(1), d); check("R3 locked while unmasked", d[7:0], 8'h51);
        wr(vpa(1), vp(1, 0, 1, 7, 8'h51));

        // R4 falling-edge polarity on source 3
        wr(vpa(3) + 4, 1);
        wr(vpa(3), vp(1, 0, 0, 3, 8'h63));
        wr(vpa(3), vp(0, 0, 0, 3, 8'h63));
        irq_src[3] = 1'b1; idle(2);
        check("R4 rising ignored in low polarity", 32'(irq_out), 0);
        irq_src[3] = 1'b0; idle(2);
        check("R4 falling latched", 32'(irq_out), 1);
        rd(8'h10, d); check("R4 falling vector", d, 8'h63);
        wr(8'h14, 0);

        // R7 / R9 arbitration over every subset
        for (int i = 0; i < NSRC; i++) begin
            wr(vpa(i) + 4, 1);
            wr(vpa(i), vp(1, 0, 1, pri_a[i], 8'h80 + i));
            wr(vpa(i), vp(1, 0, 1, pri_a[i], 8'h80 + i));
            wr(vpa(i), vp(0, 0, 1, pri_a[i], 8'h80 + i));
        end
        for (int s = 1; s < 16; s++) begin
            logic [3:0] left;
            left = 4'(s);
            @(negedge clk); irq_src = 4'(s);
            @(negedge clk); irq_src = '0;
            idle(1);
            while (left != 0) begin
                int w;
                w = -1;
                for (int i = 0; i < NSRC; i++)
                    if (left[i] && (w < 0 || pri_a[i] > pri_a[w])) w = i;
                check($sformatf("R9 irq before ack set=%0d", s), 32'(irq_out), 1);
                rd(8'h10, d);
                check($sformatf("R7 order set=%0d", s), d, 32'(8'h80 + w));
                wr(8'h14, 0);
                left[w] = 1'b0;
            end
            rd(8'h10, d); check($sformatf("R8 drained set=%0d", s), d, 8'hA5);
        end

        // R10 restart bit
        wr(8'h0C, 3);
        wr(8'h00, 1);
        rd(8'h00, d); check("R10 bit reads 1", d, 1);
        wr(8'h08, 8'h11);
        idle(RSTC + 2);
        rd(8'h00, d); check("R10 bit self-clears", d, 0);
        rd(8'h08, d); check("R10 spur restored", d, 32'hFF);
        rd(8'h0C, d); check("R10 tpri restored", d, 15);
        rd(vpa(2), d); check("R10 source restored", d, 32'h8000_0000);
        rd(vpa(2) + 4, d); check("R10 dest restored", d, 0);
        check("R10 irq low", 32'(irq_out), 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule